// File: doc/BRIEF.md
# RISC Integer Execute Stage

This block is the combinational execute stage of a small 32-bit load-store RISC pipeline. It receives one fixed-format instruction word and the two source register values that the register file has already read for it. It decodes the instruction and returns the value to write back, the index of the register that receives it, and a write strobe.

It covers register-register arithmetic, logic, constant shifts, and a set of immediate forms: add, logical AND and OR, signed set-if-less-than, and loading a constant into the upper half of a register. Any encoding outside that set is flagged as illegal, and no write-back is requested for it. The register file, memory access, branches and the multiplier are handled elsewhere. The caller supplies the source values: the register selected by bits [25:21] as the first operand and the register selected by bits [20:16] as the second.

Top module: `exe_unit`

## Requirements
- R1: With opcode 0x00 and funct 0x20 (add) or 0x22 (sub), result is srcA+srcB or srcA-srcB modulo 2^32, with no overflow trap.
- R2: With opcode 0x00, funct 0x24 gives srcA AND srcB, funct 0x25 gives srcA OR srcB, and funct 0x27 gives NOT(srcA OR srcB).
- R3: With opcode 0x00, funct 0x00 shifts srcB left and funct 0x02 shifts srcB right. The distance is instruction bits [10:6] (0 to 31), vacated bits fill with zero, and srcA has no effect on the result.
- R4: Opcode 0x08 adds srcA to the immediate bits [15:0], sign-extended from bit 15, modulo 2^32.
- R5: Opcodes 0x0C and 0x0D AND or OR srcA with the immediate zero-extended to 32 bits.
- R6: Opcode 0x0A gives 1 when signed srcA is less than the sign-extended immediate, and 0 otherwise.
- R7: Opcode 0x0F places the immediate in result bits [31:16] and zeros bits [15:0]. srcA and srcB have no effect on the result.
- R8: R-format instructions (opcode 0x00) name their destination in bits [15:11]. Immediate instructions name it in bits [20:16].
- R9: A legal instruction raises wrEn exactly when its destination index is nonzero, so register 0 is never written.
- R10: Any other opcode, or opcode 0x00 with any other funct, raises illegalInstr and drives wrEn low, result to 0 and dstIdx to 0. illegalInstr is low for every legal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction to execute |
| srcA | input | 32 | Value of the register named in bits [25:21] |
| srcB | input | 32 | Value of the register named in bits [20:16] |
| result | output | 32 | Write-back value |
| dstIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Write-back request |
| illegalInstr | output | 1 | Instruction is not in the supported set |

## Verification
The assertions evaluate only while instrWord, srcA and srcB are fully known. They assume that the inputs are held steady while the outputs settle, as they would be between pipeline edges. The bench keeps to this by changing every input together on the falling clock edge and sampling two nanoseconds later. It draws instructions at random from the legal encodings and also generates fully random words, so that illegal opcodes and funct codes turn up. Directed cases cover the wrap-around points, the extremes of the signed compare, shifts of 0 and 31, and destination 0.

// File: rtl/exe_pkg.sv
package exe_pkg;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int REG_W   = 5;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FUNCT_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SLT, ALU_LUI
  } aluOp_e;

  typedef enum logic [1:0] {IMM_NONE, IMM_SIGN, IMM_ZERO} immMode_e;

  typedef struct packed {
    aluOp_e   aluOp;
    immMode_e immMode;
    logic     dstFromRd;
    logic     legal;
  } exeCtrl_t;
endpackage

// File: rtl/exe_ctrl.sv
module exe_ctrl
  import exe_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  output exeCtrl_t           ctrl
);
  always_comb begin
    ctrl = '{aluOp: ALU_ADD, immMode: IMM_NONE, dstFromRd: 1'b0, legal: 1'b0};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dstFromRd = 1'b1;
        ctrl.legal     = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_NOR:  ctrl.aluOp = ALU_NOR;
          FN_SLL:  ctrl.aluOp = ALU_SLL;
          FN_SRL:  ctrl.aluOp = ALU_SRL;
          default: ctrl.legal = 1'b0;
        endcase
      end
      OPC_ADDI: ctrl = '{aluOp: ALU_ADD, immMode: IMM_SIGN, dstFromRd: 1'b0, legal: 1'b1};
      OPC_SLTI: ctrl = '{aluOp: ALU_SLT, immMode: IMM_SIGN, dstFromRd: 1'b0, legal: 1'b1};
      OPC_ANDI: ctrl = '{aluOp: ALU_AND, immMode: IMM_ZERO, dstFromRd: 1'b0, legal: 1'b1};
      OPC_ORI:  ctrl = '{aluOp: ALU_OR,  immMode: IMM_ZERO, dstFromRd: 1'b0, legal: 1'b1};
      OPC_LUI:  ctrl = '{aluOp: ALU_LUI, immMode: IMM_ZERO, dstFromRd: 1'b0, legal: 1'b1};
      default:  ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/exe_dp.sv
module exe_dp
  import exe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  exeCtrl_t           ctrl,
  input  logic [REG_W-1:0]   rdField,
  input  logic [REG_W-1:0]   rtField,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [IMM_W-1:0]   imm,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [DATA_W-1:0]  result,
  output logic [REG_W-1:0]   dstIdx,
  output logic               wrEn
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] aluOut;
  logic [REG_W-1:0]  dstSel;

  always_comb begin
    unique case (ctrl.immMode)
      IMM_SIGN: immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
      default:  immExt = {{EXT_W{1'b0}}, imm};
    endcase
    opB = (ctrl.immMode == IMM_NONE) ? srcB : immExt;
  end

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluOut = srcA + opB;
      ALU_SUB: aluOut = srcA - opB;
      ALU_AND: aluOut = srcA & opB;
      ALU_OR:  aluOut = srcA | opB;
      ALU_NOR: aluOut = ~(srcA | opB);
      ALU_SLL: aluOut = opB << shamt;
      ALU_SRL: aluOut = opB >> shamt;
      ALU_SLT: aluOut = {{(DATA_W-1){1'b0}}, ($signed(srcA) < $signed(opB))};
      ALU_LUI: aluOut = {imm, {EXT_W{1'b0}}};
      default: aluOut = '0;
    endcase
  end

  assign dstSel = ctrl.dstFromRd ? rdField : rtField;
  assign result = ctrl.legal ? aluOut : '0;
  assign dstIdx = ctrl.legal ? dstSel : '0;
  assign wrEn   = ctrl.legal && (dstSel != '0);
endmodule

// File: rtl/exe_unit.sv
module exe_unit
  import exe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [REG_W-1:0]  dstIdx,
  output logic              wrEn,
  output logic              illegalInstr
);
  exeCtrl_t ctrl;
  logic     unusedRsBits;

  assign unusedRsBits = ^instrWord[25:21];

  exe_ctrl u_ctrl (
    .opcode (instrWord[31:26]),
    .funct  (instrWord[5:0]),
    .ctrl   (ctrl)
  );

  exe_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .rdField (instrWord[15:11]),
    .rtField (instrWord[20:16]),
    .shamt   (instrWord[10:6]),
    .imm     (instrWord[15:0]),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .dstIdx  (dstIdx),
    .wrEn    (wrEn)
  );

  assign illegalInstr = ~ctrl.legal;
endmodule

// File: rtl/exe_unit_chk.sv
module exe_unit_chk (
  input logic [31:0] instrWord,
  input logic [31:0] srcA,
  input logic [31:0] srcB,
  input logic [31:0] result,
  input logic [4:0]  dstIdx,
  input logic        wrEn,
  input logic        illegalInstr
);
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [4:0]  sh;
  logic [31:0] lowMask;
  logic        known;

  assign opc     = instrWord[31:26];
  assign fn      = instrWord[5:0];
  assign sh      = instrWord[10:6];
  assign lowMask = (32'h1 << sh) - 32'h1;
  assign known   = !$isunknown({instrWord, srcA, srcB});

  always_comb begin
    if (known) begin
      // R10
      illegal_no_write_chk: assert (!(illegalInstr && (wrEn || result != 32'h0)));
      // R9
      zero_dst_chk: assert (!(wrEn && dstIdx == 5'd0));
      // R7
      lui_low_zero_chk: assert (!(opc == 6'h0F && result[15:0] != 16'h0));
      // R6
      slt_bool_chk: assert (!(opc == 6'h0A && result[31:1] != 31'h0));
      // R3
      sll_fill_chk: assert (!(opc == 6'h00 && fn == 6'h00 && (result & lowMask) != 32'h0));
      // R3
      srl_fill_chk: assert (!(opc == 6'h00 && fn == 6'h02 && sh != 5'd0 &&
                              (result & ~(32'hFFFF_FFFF >> sh)) != 32'h0));
      // R8
      rdest_chk: assert (!(opc == 6'h00 && !illegalInstr && dstIdx != instrWord[15:11]));
    end
  end
endmodule

bind exe_unit exe_unit_chk u_chk (
  .instrWord    (instrWord),
  .srcA         (srcA),
  .srcB         (srcB),
  .result       (result),
  .dstIdx       (dstIdx),
  .wrEn         (wrEn),
  .illegalInstr (illegalInstr)
);

// File: tb/tb_exe_unit.sv
module tb_exe_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = 32'h0;
  logic [31:0] srcA = 32'h0;
  logic [31:0] srcB = 32'h0;
  logic [31:0] result;
  logic [4:0]  dstIdx;
  logic        wrEn;
  logic        illegalInstr;
  int          nRun = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  exe_unit dut (
    .instrWord(instrWord), .srcA(srcA), .srcB(srcB),
    .result(result), .dstIdx(dstIdx), .wrEn(wrEn), .illegalInstr(illegalInstr)
  );

  typedef struct packed {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wr;
    logic        ill;
  } expect_t;

  function automatic expect_t model(logic [31:0] iw, logic [31:0] a, logic [31:0] b);
    expect_t     e;
    logic [31:0] sx = {{16{iw[15]}}, iw[15:0]};
    logic [31:0] zx = {16'h0, iw[15:0]};
    e = '{res: 32'h0, dst: 5'd0, wr: 1'b0, ill: 1'b0};
    if (iw[31:26] == 6'h00) begin
      e.dst = iw[15:11];
      case (iw[5:0])
        6'h20: e.res = a + b;
        6'h22: e.res = a - b;
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h27: e.res = ~(a | b);
        6'h00: e.res = b << iw[10:6];
        6'h02: e.res = b >> iw[10:6];
        default: e.ill = 1'b1;
      endcase
    end else begin
      e.dst = iw[20:16];
      case (iw[31:26])
        6'h08: e.res = a + sx;
        6'h0A: e.res = ($signed(a) < $signed(sx)) ? 32'h1 : 32'h0;
        6'h0C: e.res = a & zx;
        6'h0D: e.res = a | zx;
        6'h0F: e.res = {iw[15:0], 16'h0};
        default: e.ill = 1'b1;
      endcase
    end
    if (e.ill) begin
      e.res = 32'h0;
      e.dst = 5'd0;
    end
    e.wr = !e.ill && (e.dst != 5'd0);
    return e;
  endfunction

  task automatic apply(string req, logic [31:0] iw, logic [31:0] a, logic [31:0] b);
    expect_t e;
    @(negedge clk);
    instrWord = iw;
    srcA = a;
    srcB = b;
    #2;
    e = model(iw, a, b);
    nRun++;
    if ({result, dstIdx, wrEn, illegalInstr} !== e) begin
      nFail++;
      $display("FAIL %s iw=%h: got res=%h dst=%0d wr=%b ill=%b, expected res=%h dst=%0d wr=%b ill=%b",
               req, iw, result, dstIdx, wrEn, illegalInstr, e.res, e.dst, e.wr, e.ill);
    end
  endtask

  function automatic logic [31:0] rfmt(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                       logic [4:0] sh, logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ifmt(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                       logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  initial begin
    logic [5:0] fns [7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h00, 6'h02};
    logic [5:0] ops [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0F};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero word is a shift into register 0 (R9)
    apply("R9 reset", 32'h0, 32'h0, 32'h0);
    // R1 wrap
    apply("R1 add wrap", rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h1);
    apply("R1 add carry out", rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'hFFFF_FFFF, 32'h2);
    apply("R1 sub borrow", rfmt(5'd1, 5'd2, 5'd4, 5'd0, 6'h22), 32'h0, 32'h1);
    // R2
    apply("R2 nor zero", rfmt(5'd9, 5'd0, 5'd8, 5'd0, 6'h27), 32'h0000_3C00, 32'h0);
    apply("R2 and", rfmt(5'd9, 5'd10, 5'd8, 5'd0, 6'h24), 32'h0000_3C00, 32'h0000_0DC0);
    // R3 edges, srcA must not matter
    apply("R3 sll 31", rfmt(5'd7, 5'd2, 5'd5, 5'd31, 6'h00), 32'hDEAD_BEEF, 32'h0000_0003);
    apply("R3 srl 31", rfmt(5'd7, 5'd2, 5'd5, 5'd31, 6'h02), 32'h1234_5678, 32'h8000_0001);
    apply("R3 srl 0", rfmt(5'd7, 5'd2, 5'd5, 5'd0, 6'h02), 32'hFFFF_FFFF, 32'hA5A5_5A5A);
    // R4
    apply("R4 addi -1", ifmt(6'h08, 5'd17, 5'd18, 16'hFFFF), 32'h0, 32'h0);
    apply("R4 addi max", ifmt(6'h08, 5'd17, 5'd18, 16'h7FFF), 32'h1, 32'h0);
    // R5 zero-extension
    apply("R5 andi", ifmt(6'h0C, 5'd9, 5'd8, 16'hFF00), 32'hFFFF_FFFF, 32'h0);
    apply("R5 ori", ifmt(6'h0D, 5'd9, 5'd8, 16'h8000), 32'h0001_0000, 32'h0);
    // R6 signed compare
    apply("R6 slti neg<pos", ifmt(6'h0A, 5'd18, 5'd8, 16'h000F), 32'h8000_0000, 32'h0);
    apply("R6 slti equal", ifmt(6'h0A, 5'd18, 5'd8, 16'hFFFF), 32'hFFFF_FFFF, 32'h0);
    apply("R6 slti pos vs neg imm", ifmt(6'h0A, 5'd18, 5'd8, 16'h8000), 32'h0000_0005, 32'h0);
    // R7 srcs ignored
    apply("R7 lui", ifmt(6'h0F, 5'd3, 5'd8, 16'hAAAA), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R8 / R9
    apply("R8 rt dest", ifmt(6'h0D, 5'd3, 5'd31, 16'h0001), 32'h0, 32'h0);
    apply("R9 rd zero", rfmt(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'h5, 32'h6);
    apply("R9 rt zero", ifmt(6'h08, 5'd1, 5'd0, 16'h0004), 32'h5, 32'h0);
    // R10
    apply("R10 bad opcode", ifmt(6'h23, 5'd19, 5'd8, 16'h0018), 32'h1200_4094, 32'h0);
    apply("R10 bad funct", rfmt(5'd31, 5'd0, 5'd4, 5'd0, 6'h08), 32'h1, 32'h1);
    apply("R10 bad funct near add", rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h1, 32'h1);
    // random legal and random raw words
    for (int i = 0; i < 400; i++) begin
      logic [31:0] iw;
      int          pick = $urandom % 13;
      if (pick < 7)
        iw = rfmt(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), fns[pick]);
      else if (pick < 12)
        iw = ifmt(ops[pick-7], 5'($urandom), 5'($urandom), 16'($urandom));
      else
        iw = $urandom;
      apply("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10 random", iw, $urandom, $urandom);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule